// File: doc/BRIEF.md
# Banked Memory Controller with Latched Clock Registers

This block sits between a CPU bus and a banked ROM/RAM store. It decodes CPU writes in the low 32 KiB of the address space into control registers: a RAM-enable key, a 7-bit ROM bank number, a RAM-or-clock select and a clock latch command. From these it turns each bus address into a flat ROM address, a flat RAM address and RAM read/write strobes. It also flags banked ROM reads that fall beyond the fitted ROM.

The 8 KiB window at 0xA000–0xBFFF normally reaches banked RAM. When the select value names a clock register, the window reaches one of five clock registers instead: seconds, minutes, hours and two free general registers. A one-cycle `tick` input advances the seconds counter, which carries into minutes and then hours. A latch command copies all five live registers into a snapshot. While the latch flag is set, clock reads return the frozen snapshot, and the live registers keep counting.

Top module: `banked_clock_mapper`

## Requirements
- R1: After reset the ROM bank is 1, RAM is disabled, the select value is 0, the latch flag is clear and all five live and snapshot clock registers are 0.
- R2: A write in 0x0000–0x1FFF enables RAM when the data byte is exactly 0x0A and disables it for any other byte. `ram_we` and `ram_re` assert only while RAM is enabled.
- R3: A write in 0x2000–0x3FFF loads the ROM bank from data bits 6:0, and the value 0 is stored as 1. An address in 0x0000–0x3FFF maps to `rom_addr` = address. An address in 0x4000–0x7FFF maps to bank × 0x4000 + address[13:0]. `rom_addr` is 0 at or above 0x8000.
- R4: `rom_zero` is 1 for an address in 0x4000–0x7FFF when the ROM bank is at least the parameter ROM_BANKS (default 64), and 0 otherwise.
- R5: A write in 0x4000–0x5FFF with `ram_present` high loads the select value. The value is the full byte when `clock_present` is high and the byte is 0x08–0x0C, and data bits 1:0 otherwise. With `ram_present` low the write leaves the select value unchanged.
- R6: `ram_addr` is (select bits 1:0) × 0x2000 + address[12:0]. In 0xA000–0xBFFF, with no clock register selected and `ram_present` high, `cpu_wr` raises `ram_we` and `cpu_rd` raises `ram_re`, each gated by R2.
- R7: A write in 0xA000–0xBFFF while the select value is 0x08–0x0C loads live clock register (select − 0x08) with the data byte. This write is not gated by the RAM enable and takes priority over a tick on the same register.
- R8: A write in 0x6000–0x7FFF with data bit 0 set copies the live registers, as they stand before that edge, into the snapshot and sets the latch flag. With bit 0 clear the write clears the flag. The snapshot changes only on a latch-set write.
- R9: On a tick, seconds (register 0) advances, and a value of 59 or above wraps to 0 and carries into minutes (register 1). Minutes follow the same rule and carry into hours (register 2). Hours wraps at 23 or above to 0. Registers 3 and 4 do not count.
- R10: `clk_rdata` equals the selected snapshot register while latched and the selected live register otherwise. It does so only during `cpu_rd` in 0xA000–0xBFFF with a clock register selected, and it is 0 in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| ram_present | input | 1 | RAM is fitted |
| clock_present | input | 1 | Clock registers are fitted |
| tick | input | 1 | One-cycle seconds advance pulse |
| rom_addr | output | 21 | Flat ROM address |
| rom_zero | output | 1 | Banked ROM read is out of range and must read as zero |
| ram_addr | output | 15 | Flat RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| clk_rdata | output | 8 | Clock register read data |

## Verification
The directed part starts with plain ROM reads in both halves of the ROM space, including banks on either side of the ROM_BANKS limit and the zero-to-one substitution. These tell a correct bank register apart from one that stores zero or drops the high bits. Select writes are tried with bytes just inside and just outside 0x08–0x0C, once with clock or RAM absent, which shows whether the full byte or only bits 1:0 is kept. Clock sequences preload 58/59/23 and tick across the seconds, minutes and hours boundaries. A latch is set before further ticks and then cleared, so frozen and live reads return different values. A random phase mixes every address region, strobe and tick against the model on every clock.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  localparam int CLK_REGS   = 5;
  localparam int CLK_IDX_W  = 3;
  localparam int BANK_W     = 7;
  localparam int ROM_OFF_W  = 14;
  localparam int RAM_OFF_W  = 13;
  localparam int RAM_BANK_W = 2;
  localparam logic [7:0] SEC_TOP = 8'd59;
  localparam logic [7:0] MIN_TOP = 8'd59;
  localparam logic [7:0] HR_TOP  = 8'd23;

  typedef enum logic [2:0] {
    RG_ENABLE = 3'd0, RG_ROMBANK = 3'd1, RG_SELECT = 3'd2,
    RG_LATCH  = 3'd3, RG_WINDOW  = 3'd5
  } region_e;

  // advance with wrap: values at or above top return to zero
  function automatic logic [7:0] wrap_inc(input logic [7:0] v, input logic [7:0] top);
    return (v >= top) ? 8'd0 : v + 8'd1;
  endfunction

  function automatic logic is_clock_sel(input logic [3:0] s);
    return (s >= 4'h8) && (s <= 4'hC);
  endfunction

  function automatic logic [CLK_IDX_W-1:0] clock_index(input logic [3:0] s);
    return CLK_IDX_W'(s - 4'h8);
  endfunction
endpackage

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable_ev,
  input  logic              wr_rombank_ev,
  input  logic              wr_select_ev,
  input  logic [7:0]        wdata,
  input  logic              ram_present,
  input  logic              clock_present,
  output logic              ram_en,
  output logic [BANK_W-1:0] rom_bank,
  output logic [3:0]        sel
);
  logic [BANK_W-1:0] bank_raw;
  logic              sel_full;

  assign bank_raw = wdata[BANK_W-1:0];
  assign sel_full = clock_present && (wdata >= 8'h08) && (wdata <= 8'h0C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= BANK_W'(1);
      sel      <= 4'h0;
    end else begin
      if (wr_enable_ev)  ram_en <= (wdata == 8'h0A);
      if (wr_rombank_ev) rom_bank <= (bank_raw == '0) ? BANK_W'(1) : bank_raw;
      if (wr_select_ev && ram_present)
        sel <= sel_full ? wdata[3:0] : {2'b00, wdata[1:0]};
    end
  end

  p_enable_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable_ev && wdata != 8'h0A) |=> !ram_en);
  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rombank_ev && wdata[BANK_W-1:0] == '0) |=> (rom_bank == BANK_W'(1)));
  p_sel_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_select_ev && !ram_present) |=> $stable(sel));
endmodule

// File: rtl/bcm_clock.sv
module bcm_clock
  import bcm_pkg::*;
#(
  parameter int NREG  = CLK_REGS,
  parameter int IDX_W = CLK_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             snap_ev,
  input  logic             release_ev,
  input  logic             reg_wr_ev,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             frozen
);
  logic [NREG-1:0][7:0] live_q, snap_q, live_nxt;
  logic sec_carry, min_carry, sec_written;

  assign sec_carry   = live_q[0] >= SEC_TOP;
  assign min_carry   = live_q[1] >= MIN_TOP;
  assign sec_written = reg_wr_ev && (idx == '0);

  always_comb begin
    live_nxt = live_q;
    if (tick) begin
      live_nxt[0] = wrap_inc(live_q[0], SEC_TOP);
      if (sec_carry) begin
        live_nxt[1] = wrap_inc(live_q[1], MIN_TOP);
        if (min_carry) live_nxt[2] = wrap_inc(live_q[2], HR_TOP);
      end
    end
    for (int i = 0; i < NREG; i++)
      if (reg_wr_ev && idx == IDX_W'(i)) live_nxt[i] = wdata;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (idx == IDX_W'(i)) rdata = frozen ? snap_q[i] : live_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      snap_q <= '0;
      frozen <= 1'b0;
    end else begin
      live_q <= live_nxt;
      if (snap_ev) begin
        snap_q <= live_q;
        frozen <= 1'b1;
      end else if (release_ev) begin
        frozen <= 1'b0;
      end
    end
  end

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_ev |=> $stable(snap_q));
  p_sec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && live_q[0] == SEC_TOP && !sec_written) |=> (live_q[0] == 8'd0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_wr_ev) |=> $stable(live_q));
endmodule

// File: rtl/bcm_map.sv
module bcm_map
  import bcm_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int ROM_AW    = BANK_W + ROM_OFF_W,
  parameter int RAM_AW    = RAM_BANK_W + RAM_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BANK_W-1:0] rom_bank,
  input  logic [3:0]        sel,
  input  logic              ram_en,
  input  logic              ram_present,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_zero,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic              clk_wr_ev,
  output logic              clk_rd_ev
);
  localparam logic [BANK_W:0] ROM_LIMIT = (BANK_W+1)'(ROM_BANKS);

  logic in_fixed, in_banked, in_window, clock_hit, ram_hit;

  assign in_fixed  = (addr[15:14] == 2'b00);
  assign in_banked = (addr[15:14] == 2'b01);
  assign in_window = (region_e'(addr[15:13]) == RG_WINDOW);
  assign clock_hit = in_window && is_clock_sel(sel);
  assign ram_hit   = in_window && !is_clock_sel(sel) && ram_present && ram_en;

  always_comb begin
    rom_addr = '0;
    if (in_fixed)       rom_addr = ROM_AW'(addr[ROM_OFF_W-1:0]);
    else if (in_banked) rom_addr = {rom_bank, addr[ROM_OFF_W-1:0]};
  end

  assign rom_zero  = in_banked && ({1'b0, rom_bank} >= ROM_LIMIT);
  assign ram_addr  = {sel[RAM_BANK_W-1:0], addr[RAM_OFF_W-1:0]};
  assign ram_we    = ram_hit && wr;
  assign ram_re    = ram_hit && rd;
  assign clk_wr_ev = clock_hit && wr;
  assign clk_rd_ev = clock_hit && rd;

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we | ram_re, clk_wr_ev | clk_rd_ev}));
  p_fixed_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 16'h4000) |-> !rom_zero);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> !(ram_we || ram_re));
endmodule

// File: rtl/banked_clock_mapper.sv
module banked_clock_mapper
  import bcm_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int ROM_AW    = BANK_W + ROM_OFF_W,
  parameter int RAM_AW    = RAM_BANK_W + RAM_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              ram_present,
  input  logic              clock_present,
  input  logic              tick,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_zero,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [7:0]        clk_rdata
);
  region_e           region;
  logic              wr_enable_ev, wr_rombank_ev, wr_select_ev, wr_latch_ev;
  logic              snap_ev, release_ev, clk_wr_ev, clk_rd_ev, ram_en, frozen;
  logic [BANK_W-1:0] rom_bank;
  logic [3:0]        sel;
  logic [7:0]        clock_word;

  assign region        = region_e'(cpu_addr[15:13]);
  assign wr_enable_ev  = cpu_wr && (region == RG_ENABLE);
  assign wr_rombank_ev = cpu_wr && (region == RG_ROMBANK);
  assign wr_select_ev  = cpu_wr && (region == RG_SELECT);
  assign wr_latch_ev   = cpu_wr && (region == RG_LATCH);
  assign snap_ev       = wr_latch_ev && cpu_wdata[0];
  assign release_ev    = wr_latch_ev && !cpu_wdata[0];

  bcm_ctrl u_ctrl (
    .clk, .rst_n, .wr_enable_ev, .wr_rombank_ev, .wr_select_ev,
    .wdata(cpu_wdata), .ram_present, .clock_present,
    .ram_en, .rom_bank, .sel
  );

  bcm_clock u_clock (
    .clk, .rst_n, .tick, .snap_ev, .release_ev, .reg_wr_ev(clk_wr_ev),
    .idx(clock_index(sel)), .wdata(cpu_wdata), .rdata(clock_word), .frozen
  );

  bcm_map #(.ROM_BANKS(ROM_BANKS), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_map (
    .clk, .rst_n, .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .rom_bank, .sel, .ram_en, .ram_present,
    .rom_addr, .rom_zero, .ram_addr, .ram_we, .ram_re, .clk_wr_ev, .clk_rd_ev
  );

  assign clk_rdata = clk_rd_ev ? clock_word : 8'h00;

  p_latch_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ev |=> frozen);
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rd_ev |-> (clk_rdata == 8'h00));
endmodule

// File: tb/tb_banked_clock_mapper.sv
module tb_banked_clock_mapper;
  localparam int NB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 0, cpu_wr = 0, ram_present = 1, clock_present = 1, tick = 0;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic rom_zero, ram_we, ram_re;
  logic [7:0] clk_rdata;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R1";

  // reference model state
  int m_en, m_rb, m_sel, m_lat;
  int m_live[5];
  int m_snap[5];

  always #2.5 clk = ~clk;

  banked_clock_mapper #(.ROM_BANKS(NB)) dut (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_rd, .cpu_wr, .ram_present,
    .clock_present, .tick, .rom_addr, .rom_zero, .ram_addr, .ram_we, .ram_re,
    .clk_rdata
  );

  function automatic int adv(int v, int top);
    return (v >= top) ? 0 : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rb = 1; m_sel = 0; m_lat = 0;
      foreach (m_live[i]) begin m_live[i] = 0; m_snap[i] = 0; end
    end else begin
      int old[5];
      int d, reg_n;
      old = m_live;
      d = cpu_wdata;
      reg_n = cpu_addr / 8192;
      if (tick) begin
        m_live[0] = adv(old[0], 59);
        if (old[0] >= 59) begin
          m_live[1] = adv(old[1], 59);
          if (old[1] >= 59) m_live[2] = adv(old[2], 23);
        end
      end
      if (cpu_wr) begin
        case (reg_n)
          0: m_en = (d == 10);
          1: begin m_rb = d % 128; if (m_rb == 0) m_rb = 1; end
          2: if (ram_present) m_sel = (clock_present && d >= 8 && d <= 12) ? d : d % 4;
          3: if (d % 2 == 1) begin m_snap = old; m_lat = 1; end else m_lat = 0;
          5: if (m_sel >= 8 && m_sel <= 12) m_live[m_sel-8] = d;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t: got %0h expected %0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int a, e_rom, e_zero, e_ram, win, cs, hit, e_clk;
      a = cpu_addr;
      win = (a / 8192 == 5);
      cs = (m_sel >= 8 && m_sel <= 12);
      e_rom = (a < 16384) ? a : (a < 32768) ? m_rb * 16384 + a % 16384 : 0;
      e_zero = (a >= 16384 && a < 32768 && m_rb >= NB);
      e_ram = (m_sel % 4) * 8192 + a % 8192;
      hit = win && !cs && ram_present && m_en;
      e_clk = (win && cs && cpu_rd) ? (m_lat ? m_snap[m_sel-8] : m_live[m_sel-8]) : 0;
      check("R3 rom_addr", int'(rom_addr), e_rom);
      check("R4 rom_zero", int'(rom_zero), e_zero);
      check("R6 ram_addr", int'(ram_addr), e_ram);
      check("R6/R2 ram_we", int'(ram_we), hit && cpu_wr);
      check("R6/R2 ram_re", int'(ram_re), hit && cpu_rd);
      check("R10 clk_rdata", int'(clk_rdata), e_clk);
    end
  end

  // one bus cycle: inputs change just after the rising edge
  task automatic bus(int a, int d, bit rd, bit wr, bit tk);
    @(posedge clk); #1;
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_rd = rd; cpu_wr = wr; tick = tk;
  endtask
  task automatic wr_(int a, int d); bus(a, d, 0, 1, 0); endtask
  task automatic rd_(int a);        bus(a, 0, 1, 0, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1";
    rd_(16'h4000); rd_(16'hA000); rd_(16'h0123);
    phase = "R2";
    wr_(16'h0000, 8'h0B); rd_(16'hA010); wr_(16'hA010, 8'h55);
    wr_(16'h1FFF, 8'h0A); rd_(16'hA010); wr_(16'hA011, 8'h66);
    wr_(16'h0100, 8'h00); rd_(16'hA010);
    wr_(16'h0000, 8'h0A);
    phase = "R3";
    wr_(16'h2000, 8'h00); rd_(16'h4000); rd_(16'h3FFF);
    wr_(16'h3000, 8'h85); rd_(16'h7FFF);
    wr_(16'h2ABC, 8'h80); rd_(16'h5555); rd_(16'h8000);
    phase = "R4";
    wr_(16'h2000, 8'h3F); rd_(16'h4000);
    wr_(16'h2000, 8'h40); rd_(16'h4000); rd_(16'h1000);
    wr_(16'h2000, 8'h7F); rd_(16'h7000);
    phase = "R5";
    wr_(16'h4000, 8'h02); rd_(16'hA123);
    wr_(16'h5FFF, 8'h07); rd_(16'hB000);
    wr_(16'h4000, 8'h0D); rd_(16'hA000);
    wr_(16'h4000, 8'h07); wr_(16'h4000, 8'h0C); rd_(16'hA000);
    clock_present = 0; wr_(16'h4000, 8'h09); rd_(16'hA000); clock_present = 1;
    ram_present = 0; wr_(16'h4000, 8'h03); rd_(16'hA000); wr_(16'hA000, 8'h11);
    ram_present = 1;
    phase = "R7";
    wr_(16'h4000, 8'h08); wr_(16'hA000, 8'd58);
    wr_(16'h4000, 8'h09); wr_(16'hA000, 8'd59);
    wr_(16'h4000, 8'h0A); wr_(16'hA000, 8'd23);
    wr_(16'h4000, 8'h0B); wr_(16'hBFFF, 8'hAB);
    wr_(16'h4000, 8'h0C); wr_(16'hA001, 8'hCD); rd_(16'hA000);
    phase = "R9";
    wr_(16'h4000, 8'h08); bus(16'hA000, 0, 1, 0, 1); bus(16'hA000, 0, 1, 0, 1);
    wr_(16'h4000, 8'h09); rd_(16'hA000); wr_(16'h4000, 8'h0A); rd_(16'hA000);
    wr_(16'h4000, 8'h08); bus(16'hA000, 8'd30, 0, 1, 1); rd_(16'hA000);
    phase = "R8";
    wr_(16'h6000, 8'h01);
    for (int i = 0; i < 40; i++) bus(16'hA000, 0, 1, 0, 1);
    wr_(16'h4000, 8'h09); rd_(16'hA000);
    wr_(16'h6000, 8'h00); rd_(16'hA000);
    wr_(16'h4000, 8'h08); rd_(16'hA000);
    phase = "R10";
    rd_(16'hA000); bus(16'hA000, 0, 0, 0, 0); rd_(16'hC000);
    wr_(16'h4000, 8'h01); rd_(16'hA000);
    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      int r, a, d;
      r = $urandom % 8;
      a = r * 8192 + ($urandom % 8192);
      d = ($urandom % 3 == 0) ? 8 + $urandom % 6 : $urandom % 256;
      if ($urandom % 8 == 0) d = 8'h0A;
      ram_present = ($urandom % 10 != 0);
      clock_present = ($urandom % 10 != 0);
      case ($urandom % 3)
        0: bus(a, d, 1, 0, $urandom % 2);
        1: bus(a, d, 0, 1, $urandom % 2);
        default: bus(a, d, 0, 0, $urandom % 2);
      endcase
    end
    bus(0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule